// File: doc/BRIEF.md
# Encoded Programmable Clock Divider

This block produces a slower clock from a fast input clock. A 4-bit divide code chooses the ratio. The lower field picks an odd-or-two base, and the upper field scales that base by a power of two. A map-select input swaps in a second ratio map, where the even base is four instead of two. The output keeps a 50% duty cycle for every ratio, odd ones included. It does this by combining a rising-edge phase register with a copy of it taken on the falling edge.

During reset the divide code is taken from a strap input, and the output is held low. After reset, a one-cycle register write can replace both the divide code and the phase-invert flag. A new code, a new map selection or a new invert flag never changes an output period that has already started. It is captured at the clock edge where the period counter wraps, so the output never shows a runt pulse.

Top module: `ratio_clk_divider`

## Requirements
- R1: Divide code bits [1:0] select the base divisor: 00 gives 2, 01 gives 3, 10 gives 5, 11 gives 7 (with `map_alt_i` = 0).
- R2: Divide code bits [3:2] multiply the base by 1, 2, 4 or 8 for 00, 01, 10, 11, giving output periods from 2 to 56 input clock cycles.
- R3: With `map_alt_i` = 1 the base for bits [1:0] = 00 is 4, so that row gives periods of 4, 8, 16 and 32. The bases 3, 5 and 7 are unchanged.
- R4: For a period of N input cycles, the output is high for exactly N half-cycles and low for exactly N half-cycles, for odd and even N.
- R5: When the active invert flag is 1, the output is the complement of the non-inverted waveform. Reset clears the invert flag.
- R6: While `rst_ni` is low at rising edges, the divide code loads `strap_code_i` and the output is low. The first rising clock edge with `rst_ni` high starts a period, and the output (not inverted) rises at the following falling clock edge.
- R7: `wr_en_i` high at a rising edge loads `wr_code_i` as the divide code and `wr_inv_i` as the invert flag.
- R8: Code, map and invert changes are applied only at the rising edge where the period counter wraps. A write sampled at that same edge is applied at the next wrap, so the running period completes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock; both edges are used |
| rst_ni | input | 1 | Synchronous active-low reset |
| strap_code_i | input | 4 | Divide code loaded during reset |
| map_alt_i | input | 1 | 1 selects the ratio map with even base 4 |
| wr_en_i | input | 1 | One-cycle register write strobe |
| wr_code_i | input | 4 | Divide code to write |
| wr_inv_i | input | 1 | Invert flag to write |
| div_clk_o | output | 1 | Divided output clock |

## Verification
A register write and a period wrap can be sampled on the same rising edge. The write must then miss that wrap, and the running period must complete at its old length. The bench starts from reset with a period of 3, counts rising edges since release, and places a write of code 00 either one edge before the wrap at edge 7 or exactly on it. The scoreboard expects, respectively, periods of 2 from edge 7 on, or one more period of 3 followed by periods of 2, each measured in half-cycles of high and low time.

// File: rtl/ratio_div_pkg.sv
// Package: shared widths and types for the encoded clock divider.
// Assumes the code is a base-select field below a power-of-two scale field.
package ratio_div_pkg;
    localparam int SEL_W     = 2;
    localparam int MUL_W     = 2;
    localparam int CODE_W    = SEL_W + MUL_W;
    localparam int MAX_BASE  = 7;
    localparam int MAX_SHIFT = (1 << MUL_W) - 1;
    localparam int MAX_RATIO = MAX_BASE * (1 << MAX_SHIFT);
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    // Decoded ratio with its high-phase length and parity.
    typedef struct packed {
        ratio_t ratio;
        ratio_t half;
        logic   odd;
    } ratio_info_t;
endpackage

// File: rtl/ratio_div_ctrl_reg.sv
// Module: holds the divide code and the invert flag.
// Loads the strap code during reset and takes a one-cycle write afterwards.
// Assumes the write strobe is synchronous to clk_i.
module ratio_div_ctrl_reg
    import ratio_div_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  code_t strap_i,
    input  logic  wr_en_i,
    input  code_t wr_code_i,
    input  logic  wr_inv_i,
    output code_t code_o,
    output logic  inv_o
);
    code_t code_q;
    logic  inv_q;

    // Strap load under reset, write port afterwards.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            code_q <= strap_i;
            inv_q  <= 1'b0;
        end else if (wr_en_i) begin
            code_q <= wr_code_i;
            inv_q  <= wr_inv_i;
        end
    end

    assign code_o = code_q;
    assign inv_o  = inv_q;
endmodule

// File: rtl/ratio_div_decode.sv
// Module: maps a divide code and map select to a ratio, its high-phase length and parity.
// Pure combinational. Assumes the even bases are given as parameters, with ALT used when alt_i=1.
module ratio_div_decode
    import ratio_div_pkg::*;
#(
    parameter int EVEN_BASE_STD = 2,
    parameter int EVEN_BASE_ALT = 4
) (
    input  code_t       code_i,
    input  logic        alt_i,
    output ratio_info_t info_o
);
    logic [SEL_W-1:0] sel;
    logic [MUL_W-1:0] scale;
    ratio_t           base;
    ratio_t           ratio;

    assign sel   = code_i[SEL_W-1:0];
    assign scale = code_i[CODE_W-1:SEL_W];

    // Base divisor from the low field.
    always_comb begin
        case (sel)
            2'd0:    base = alt_i ? RATIO_W'(EVEN_BASE_ALT) : RATIO_W'(EVEN_BASE_STD);
            2'd1:    base = RATIO_W'(3);
            2'd2:    base = RATIO_W'(5);
            default: base = RATIO_W'(7);
        endcase
    end

    // Power-of-two scaling and derived fields.
    always_comb begin
        ratio        = base << scale;
        info_o.ratio = ratio;
        info_o.half  = RATIO_W'((ratio + RATIO_W'(1)) >> 1);
        info_o.odd   = ratio[0];
    end
endmodule

// File: rtl/ratio_div_counter.sv
// Module: rising-edge period counter and phase register.
// Captures the requested ratio and invert flag only when the counter wraps.
// Under reset it preloads the count to the last value, so the first edge after reset starts a full period.
// Assumes ratio_i is at least 2.
module ratio_div_counter
    import ratio_div_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  ratio_info_t info_i,
    input  logic        inv_i,
    output logic        phase_o,
    output logic        odd_o,
    output logic        inv_o,
    output ratio_t      cnt_o,
    output ratio_t      ratio_o,
    output logic        wrap_o
);
    ratio_t cnt_q;
    ratio_t ratio_q;
    ratio_t half_q;
    logic   odd_q;
    logic   inv_q;
    logic   phase_q;
    ratio_t cnt_inc;

    assign cnt_inc = cnt_q + RATIO_W'(1);
    assign wrap_o  = (cnt_q == ratio_q - RATIO_W'(1));

    // Count, wrap and capture new settings at the period boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= info_i.ratio - RATIO_W'(1);
            ratio_q <= info_i.ratio;
            half_q  <= info_i.half;
            odd_q   <= info_i.odd;
            inv_q   <= 1'b0;
            phase_q <= 1'b0;
        end else if (wrap_o) begin
            cnt_q   <= '0;
            ratio_q <= info_i.ratio;
            half_q  <= info_i.half;
            odd_q   <= info_i.odd;
            inv_q   <= inv_i;
            phase_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_inc;
            phase_q <= (cnt_inc < half_q);
        end
    end

    assign phase_o = phase_q;
    assign odd_o   = odd_q;
    assign inv_o   = inv_q;
    assign cnt_o   = cnt_q;
    assign ratio_o = ratio_q;
endmodule

// File: rtl/ratio_div_phase_out.sv
// Module: falling-edge stage that builds the output with 50% duty cycle.
// Even ratios use the half-cycle delayed phase. Odd ratios AND it with the undelayed phase.
// The invert flag is retimed on the falling edge so that it flips together with the delayed phase.
module ratio_div_phase_out (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic phase_i,
    input  logic odd_i,
    input  logic inv_i,
    output logic out_o
);
    logic phase_n_q;
    logic inv_n_q;
    logic shaped;

    // Half-cycle delayed copies of the phase and the invert flag.
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            phase_n_q <= 1'b0;
            inv_n_q   <= 1'b0;
        end else begin
            phase_n_q <= phase_i;
            inv_n_q   <= inv_i;
        end
    end

    // Duty-cycle shaping and inversion.
    always_comb begin
        shaped = odd_i ? (phase_i & phase_n_q) : phase_n_q;
        out_o  = shaped ^ inv_n_q;
    end
endmodule

// File: rtl/ratio_clk_divider.sv
// Module: top of the encoded programmable clock divider.
// Chains the control register, the ratio decoder, the period counter and the output stage.
// During reset the strap code feeds the decoder directly, so one reset cycle is enough.
module ratio_clk_divider
    import ratio_div_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] strap_code_i,
    input  logic              map_alt_i,
    input  logic              wr_en_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              wr_inv_i,
    output logic              div_clk_o
);
    code_t       code_q;
    logic        inv_q;
    code_t       code_eff;
    ratio_info_t info;
    logic        phase;
    logic        odd_act;
    logic        inv_act;
    ratio_t      cnt;
    ratio_t      ratio_act;
    logic        wrap;

    ratio_div_ctrl_reg u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strap_i   (strap_code_i),
        .wr_en_i   (wr_en_i),
        .wr_code_i (wr_code_i),
        .wr_inv_i  (wr_inv_i),
        .code_o    (code_q),
        .inv_o     (inv_q)
    );

    // Strap bypass while in reset.
    always_comb begin
        code_eff = rst_ni ? code_q : strap_code_i;
    end

    ratio_div_decode u_dec (
        .code_i (code_eff),
        .alt_i  (map_alt_i),
        .info_o (info)
    );

    ratio_div_counter u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .info_i  (info),
        .inv_i   (inv_q),
        .phase_o (phase),
        .odd_o   (odd_act),
        .inv_o   (inv_act),
        .cnt_o   (cnt),
        .ratio_o (ratio_act),
        .wrap_o  (wrap)
    );

    ratio_div_phase_out u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (phase),
        .odd_i   (odd_act),
        .inv_i   (inv_act),
        .out_o   (div_clk_o)
    );
endmodule

// File: rtl/ratio_div_checker.sv
// Module: property checker bound to the divider top.
// Observes the control register, the counter state and the output phase.
module ratio_div_checker
    import ratio_div_pkg::*;
(
    input logic   clk_i,
    input logic   rst_ni,
    input code_t  strap_code_i,
    input logic   wr_en_i,
    input code_t  wr_code_i,
    input logic   wr_inv_i,
    input code_t  code_q,
    input logic   inv_q,
    input ratio_t cnt,
    input ratio_t ratio_act,
    input logic   wrap,
    input logic   phase
);
    // R6: reset loads the strap and clears the invert flag.
    a_r6_strap_load: assert property (@(posedge clk_i)
        !rst_ni |=> (code_q == $past(strap_code_i)) && !inv_q);

    // R6: the phase register is low after a reset edge.
    a_r6_idle_low: assert property (@(posedge clk_i)
        !rst_ni |=> !phase);

    // R7: a write lands in the control register.
    a_r7_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (code_q == $past(wr_code_i)) && (inv_q == $past(wr_inv_i)));

    // R8: the active ratio holds between wraps.
    a_r8_hold_midperiod: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(ratio_act));

    // R4: the counter stays inside the active period.
    a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt < ratio_act);

    // R4: each period begins with the high phase.
    a_r4_wrap_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> phase);

    // R2: the active ratio lies within 2 to the maximum ratio.
    a_r2_ratio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ratio_act >= RATIO_W'(2)) && (ratio_act <= RATIO_W'(MAX_RATIO)));
endmodule

bind ratio_clk_divider ratio_div_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_code_i (strap_code_i),
    .wr_en_i      (wr_en_i),
    .wr_code_i    (wr_code_i),
    .wr_inv_i     (wr_inv_i),
    .code_q       (code_q),
    .inv_q        (inv_q),
    .cnt          (cnt),
    .ratio_act    (ratio_act),
    .wrap         (wrap),
    .phase        (phase)
);

// File: tb/tb_ratio_clk_divider.sv
`timescale 1ns/1ps
module tb_ratio_clk_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] strap_code = 4'd0;
    logic       map_alt = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_code = 4'd0;
    logic       wr_inv = 1'b0;
    logic       div_clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct { int n; string tag; } exp_t;
    exp_t q[$];
    bit   meas = 0;
    bit   prev = 0;
    int   hi_cnt = 0;
    int   lo_cnt = 0;

    always #2.5 clk = ~clk;

    ratio_clk_divider dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .strap_code_i (strap_code),
        .map_alt_i    (map_alt),
        .wr_en_i      (wr_en),
        .wr_code_i    (wr_code),
        .wr_inv_i     (wr_inv),
        .div_clk_o    (div_clk)
    );

    // Rising edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Expected period from the requirement tables (R1, R2, R3).
    function automatic int exp_ratio(input logic [3:0] code, input logic alt);
        int base;
        case (code[1:0])
            2'd0:    base = alt ? 4 : 2;
            2'd1:    base = 3;
            2'd2:    base = 5;
            default: base = 7;
        endcase
        return base << code[3:2];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: half-cycle samples, period = rise to rise.
    initial begin
        forever begin
            @(posedge clk or negedge clk);
            #1;
            if (div_clk === 1'b1 && !prev) begin
                if (meas) begin
                    exp_t e;
                    e = q.pop_front();
                    check(hi_cnt == e.n, {e.tag, " high half-cycles"}, hi_cnt, e.n);
                    check(lo_cnt == e.n, {e.tag, " low half-cycles"}, lo_cnt, e.n);
                end
                meas = (q.size() > 0);
                hi_cnt = 0;
                lo_cnt = 0;
            end
            if (meas) begin
                if (div_clk === 1'b1) hi_cnt++;
                else                  lo_cnt++;
            end
            prev = (div_clk === 1'b1);
        end
    end

    task automatic push(input int n, input string tag);
        exp_t e;
        e.n = n;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drive_at();
        @(posedge clk);
        #2;
    endtask

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (q.size() != 0 || meas) at_neg();
    endtask

    task automatic do_write(input logic [3:0] code, input logic inv);
        drive_at();
        wr_en = 1'b1; wr_code = code; wr_inv = inv;
        drive_at();
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] strap, input logic alt);
        drive_at();
        rst_n = 1'b0; strap_code = strap; map_alt = alt;
        repeat (3) drive_at();
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int k);
        while (cyc != k) drive_at();
    endtask

    initial begin
        // R6: output low during reset, strap ratio, first rise half a cycle after release.
        strap_code = 4'b0101;
        repeat (3) at_neg();
        check(div_clk === 1'b0, "R6 low in reset", div_clk, 0);
        at_neg();
        check(div_clk === 1'b0, "R6 low in reset", div_clk, 0);
        drive_at();
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(div_clk === 1'b0, "R6 low at first edge", div_clk, 0);
        at_neg();
        check(div_clk === 1'b1, "R6 rises at first falling edge", div_clk, 1);
        push(6, "R6 strap ratio /6");
        push(6, "R6 strap ratio /6");
        drain();

        // R1 R2 R3 R4: sweep of all codes in both maps.
        for (int alt = 0; alt < 2; alt++) begin
            for (int c = 0; c < 16; c++) begin
                drive_at();
                map_alt = alt[0];
                do_write(c[3:0], 1'b0);
                repeat (60) drive_at();
                push(exp_ratio(c[3:0], alt[0]),
                     $sformatf("R1 R2 R3 R4 code=%0d map=%0d", c, alt));
                drain();
            end
        end

        // R5: phase with period 2, then inverted after a write.
        do_reset(4'b0000, 1'b0);
        for (int k = 0; k < 4; k++) begin
            at_neg();
            check(div_clk === (cyc[0] == 1'b1), "R5 plain phase", div_clk, cyc[0]);
        end
        do_write(4'b0000, 1'b1);
        repeat (4) drive_at();
        for (int k = 0; k < 4; k++) begin
            at_neg();
            check(div_clk === (cyc[0] != 1'b1), "R5 inverted phase", div_clk, !cyc[0]);
        end
        push(2, "R5 inverted duty");
        drain();
        // R5: reset clears the invert flag.
        do_reset(4'b0000, 1'b0);
        repeat (2) drive_at();
        for (int k = 0; k < 2; k++) begin
            at_neg();
            check(div_clk === (cyc[0] == 1'b1), "R5 invert cleared by reset", div_clk, cyc[0]);
        end

        // R7 R8: write sampled one edge before the wrap at edge 7 (period 3).
        do_reset(4'b0001, 1'b0);
        wait_cyc(5);
        wr_en = 1'b1; wr_code = 4'b0000; wr_inv = 1'b0;
        push(2, "R7 R8 write before wrap");
        push(2, "R7 R8 write before wrap");
        drive_at();
        wr_en = 1'b0;
        drain();

        // R8: write sampled on the wrap edge, old period finishes first.
        do_reset(4'b0001, 1'b0);
        wait_cyc(6);
        wr_en = 1'b1; wr_code = 4'b0000; wr_inv = 1'b0;
        push(3, "R8 write on wrap keeps old period");
        push(2, "R8 write on wrap new period");
        push(2, "R8 write on wrap new period");
        drive_at();
        wr_en = 1'b0;
        drain();

        // R3 R8: map switch mid-period applies at the next wrap (code 0100: /4 to /8).
        do_write(4'b0100, 1'b0);
        repeat (12) drive_at();
        map_alt = 1'b1;
        repeat (12) drive_at();
        push(8, "R3 R8 map switch");
        push(8, "R3 R8 map switch");
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #750000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule